// File: doc/BRIEF.md
# Multiplexed Channel Program Sequencer

This block steps up to sixteen device subchannels through their channel programs, one subchannel at a time. Each subchannel's progress lives in three small context stores: the phase it will run next, its program address register and the order it is executing. When a device raises its service request line, the block picks one subchannel, asks the I/O processor for the bus with a high-speed request, and on the returned data poll copies that subchannel's context into working registers.

From the working registers the block runs exactly one step for the subchannel. A step either fetches a command word, fetches the second program word, or stores the program address back to memory. The order code decides which second-word path is taken and which command goes to the device controller: load its control register, arm an inbound transfer, arm an outbound transfer, or decide a conditional jump. At the end of the step the updated context is written back and the block returns to idle.

Memory traffic goes through the processor as a simple request/done handshake carrying an address. The device controller sees a one-cycle command strobe with a command code and a data word.

Top module: `mux_chan_seq`

## Requirements
- R1: After reset the block holds `hs_req`, `xfer_valid` and `dev_cmd_valid` low, and every subchannel starts with a command-word fetch at address `id << (WORD_W - log2(NSUB))` (for the defaults, `id * 16'h1000`).
- R2: Requests are taken only while the block is idle. Among the set `svc_req` bits the lowest index wins and is shown on `active_sub`. `active_sub` holds until the step ends, even if other request bits rise meanwhile.
- R3: After a request is taken, `hs_req` stays high until `poll_gnt` is seen. In the next cycle `hs_req` and `xfer_valid` are both low, and `xfer_valid` rises in the cycle after that.
- R4: A command-word step issues a from-memory transfer (`xfer_to_mem`=0) at the program address. When it completes, the order code in bits [WORD_W-1:WORD_W-4] of `word_in` is stored and the program address advances by one.
- R5: Order codes 0 (Read), 1 (Write), 2 (Jump), 3 (Conditional Jump), 4 (Control) and 5 (Interrupt) take the second-word fetch path. Codes 6 (Sense), 7 (End), 8 (Return Residue) and the unused codes 9 to 15 take the second-word store path.
- R6: When the fetched command word carries order 4, the device controller receives command 1 (load control register) with the command word as data.
- R7: A second-word fetch issues a from-memory transfer at the program address. For orders 0, 1, 2, 3 and 5 the returned word replaces the program address. For order 4 it is sent with command 1, and the program address is left unchanged.
- R8: After the second word, order 0 issues command 2 (arm inbound transfer), order 1 issues command 3 (arm outbound transfer) and order 3 issues command 4 (jump decision). Order 5 issues no command, so the Interrupt word has no effect beyond the program address.
- R9: A second-word store issues a to-memory transfer (`xfer_to_mem`=1) at the incremented program address and issues no device command. The next step of that subchannel is a command-word fetch.
- R10: For the step after a Jump or Conditional Jump second word, `dev_jump_met` is sampled in the cycle after the poll. If the order is 2, or `dev_jump_met` is 1, the block stores the jump target (to-memory transfer at the program address) and then fetches commands from that target. Otherwise it fetches a fresh program pointer from address `id`, and the returned word becomes the program address.
- R11: `dev_cmd_valid` is a single-cycle strobe in the cycle right after a completed transfer. Command code 0 is never strobed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| svc_req | input | NSUB | Per-subchannel service request |
| hs_req | output | 1 | High-speed request to the I/O processor |
| poll_gnt | input | 1 | Data poll grant from the processor |
| xfer_valid | output | 1 | Memory transfer request to the processor |
| xfer_to_mem | output | 1 | 1 = transfer to memory, 0 = transfer from memory |
| xfer_addr | output | WORD_W | Address driven for the transfer |
| xfer_done | input | 1 | Processor completes the transfer |
| word_in | input | WORD_W | Word returned by a from-memory transfer |
| dev_cmd_valid | output | 1 | Device controller command strobe |
| dev_cmd | output | 3 | Command code: 1 load control, 2 arm in, 3 arm out, 4 jump decision |
| dev_cmd_word | output | WORD_W | Data word for the command |
| dev_jump_met | input | 1 | Jump condition from the device controller |
| active_sub | output | log2(NSUB) | Subchannel being serviced |

## Verification
The hardest case to reach from the ports is the third step of a jump program. The not-taken branch needs one subchannel to run a Conditional Jump through its command and second-word steps while `dev_jump_met` is low at the next poll. The effect only shows one step later, at the address of the following command fetch. The bench drives four consecutive service steps on every subchannel, with its order code and jump condition chosen from its index, so both jump outcomes and every order path are reached. It also runs an overlapping-request sequence in which new request bits rise during a step, to show they wait for idle and lose to lower indices.

// File: rtl/mcs_pkg.sv
// Shared constants and types for the multiplexed channel program sequencer.
// Assumes a 4-bit order field at the top of every command word.
package mcs_pkg;
    localparam int ORD_W = 4;

    localparam logic [ORD_W-1:0] ORD_READ  = 4'd0;
    localparam logic [ORD_W-1:0] ORD_WRITE = 4'd1;
    localparam logic [ORD_W-1:0] ORD_JUMP  = 4'd2;
    localparam logic [ORD_W-1:0] ORD_JUMPC = 4'd3;
    localparam logic [ORD_W-1:0] ORD_CTRL  = 4'd4;
    localparam logic [ORD_W-1:0] ORD_INTR  = 4'd5;

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_ARGF = 2'd1,
        PH_ARGS = 2'd2,
        PH_JMP  = 2'd3
    } phase_e;

    typedef enum logic [2:0] {
        DC_NONE      = 3'd0,
        DC_LOAD_CTRL = 3'd1,
        DC_SET_IN    = 3'd2,
        DC_SET_OUT   = 3'd3,
        DC_JUMP_ASK  = 3'd4
    } devcmd_e;

    // True when the order's second word is fetched rather than stored
    function automatic logic takes_fetch(input logic [ORD_W-1:0] o);
        return o <= ORD_INTR;
    endfunction

    // True when the fetched second word replaces the program address
    function automatic logic keeps_word(input logic [ORD_W-1:0] o);
        return (o <= ORD_JUMPC) || (o == ORD_INTR);
    endfunction
endpackage

// File: rtl/mcs_prio_arb.sv
// Fixed-priority picker: the lowest set request index wins.
// Purely combinational; the caller samples it only when idle.
module mcs_prio_arb #(
    parameter int N = 16
) (
    input  logic [N-1:0]         req,
    output logic                 any,
    output logic [$clog2(N)-1:0] idx
);
    localparam int IW = $clog2(N);

    // Scan from the top so the lowest set bit is the last to write idx
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/mcs_ctx_store.sv
// Per-subchannel context: next phase, program address and current order.
// Read is asynchronous, write is one entry per cycle. On reset each entry
// starts at a command fetch with its index in the top address bits.
module mcs_ctx_store
    import mcs_pkg::*;
#(
    parameter int N      = 16,
    parameter int WORD_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [$clog2(N)-1:0] rd_idx,
    output phase_e               rd_phase,
    output logic [WORD_W-1:0]    rd_addr,
    output logic [ORD_W-1:0]     rd_order,
    input  logic                 we,
    input  logic [$clog2(N)-1:0] wr_idx,
    input  phase_e               wr_phase,
    input  logic [WORD_W-1:0]    wr_addr,
    input  logic [ORD_W-1:0]     wr_order
);
    localparam int IW = $clog2(N);
    localparam int SH = WORD_W - IW;

    phase_e            ph_q [N];
    logic [WORD_W-1:0] ad_q [N];
    logic [ORD_W-1:0]  or_q [N];

    for (genvar g = 0; g < N; g++) begin : g_entry
        // One context entry: reset to its start address, else take a write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ph_q[g] <= PH_CMD;
                ad_q[g] <= WORD_W'(g) << SH;
                or_q[g] <= '0;
            end else if (we && (wr_idx == IW'(g))) begin
                ph_q[g] <= wr_phase;
                ad_q[g] <= wr_addr;
                or_q[g] <= wr_order;
            end
        end
    end

    assign rd_phase = ph_q[rd_idx];
    assign rd_addr  = ad_q[rd_idx];
    assign rd_order = or_q[rd_idx];
endmodule

// File: rtl/mcs_order_dec.sv
// Order decoder: for a completed fetch step, chooses the next phase, the
// device command and whether the returned word becomes the program address.
module mcs_order_dec
    import mcs_pkg::*;
(
    input  logic             cmd_step,
    input  logic             reload,
    input  logic [ORD_W-1:0] cur_order,
    input  logic [ORD_W-1:0] word_order,
    output phase_e           nxt_phase,
    output devcmd_e          dcmd,
    output logic             addr_load
);
    // Decode the step kind and order into the writeback controls
    always_comb begin
        nxt_phase = PH_CMD;
        dcmd      = DC_NONE;
        addr_load = 1'b0;
        if (cmd_step) begin
            nxt_phase = takes_fetch(word_order) ? PH_ARGF : PH_ARGS;
            if (word_order == ORD_CTRL) dcmd = DC_LOAD_CTRL;
        end else if (reload) begin
            addr_load = 1'b1;
        end else begin
            addr_load = keeps_word(cur_order);
            if (cur_order == ORD_JUMP || cur_order == ORD_JUMPC) nxt_phase = PH_JMP;
            unique case (cur_order)
                ORD_READ:  dcmd = DC_SET_IN;
                ORD_WRITE: dcmd = DC_SET_OUT;
                ORD_JUMPC: dcmd = DC_JUMP_ASK;
                ORD_CTRL:  dcmd = DC_LOAD_CTRL;
                default:   dcmd = DC_NONE;
            endcase
        end
    end
endmodule

// File: rtl/mux_chan_seq.sv
// Multiplexed channel program sequencer, top level. Services one subchannel
// per pass: request, poll, one transfer step, context writeback. Assumes the
// processor answers hs_req with a one-cycle poll_gnt and each transfer with
// a one-cycle xfer_done.
module mux_chan_seq
    import mcs_pkg::*;
#(
    parameter int NSUB   = 16,
    parameter int WORD_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NSUB-1:0]         svc_req,
    output logic                    hs_req,
    input  logic                    poll_gnt,
    output logic                    xfer_valid,
    output logic                    xfer_to_mem,
    output logic [WORD_W-1:0]       xfer_addr,
    input  logic                    xfer_done,
    input  logic [WORD_W-1:0]       word_in,
    output logic                    dev_cmd_valid,
    output logic [2:0]              dev_cmd,
    output logic [WORD_W-1:0]       dev_cmd_word,
    input  logic                    dev_jump_met,
    output logic [$clog2(NSUB)-1:0] active_sub
);
    localparam int SUB_W  = $clog2(NSUB);
    localparam int NST    = 7;
    localparam int S_IDLE = 0;
    localparam int S_REQ  = 1;
    localparam int S_POLL = 2;
    localparam int S_CMDF = 3;
    localparam int S_ARGF = 4;
    localparam int S_ARGS = 5;
    localparam int S_UPD  = 6;

    logic [NST-1:0]    st_q, st_d;
    logic [SUB_W-1:0]  sel_q;
    phase_e            ctx_phase_q;
    logic [WORD_W-1:0] ctx_addr_q;
    logic [ORD_W-1:0]  ctx_order_q;
    logic              reload_q;
    logic              dcmd_vld_q;
    devcmd_e           dcmd_q;
    logic [WORD_W-1:0] dcmd_word_q;

    logic              arb_any;
    logic [SUB_W-1:0]  arb_idx;
    phase_e            rd_phase;
    logic [WORD_W-1:0] rd_addr;
    logic [ORD_W-1:0]  rd_order;
    phase_e            dec_phase;
    devcmd_e           dec_cmd;
    logic              dec_addr_load;
    logic [ORD_W-1:0]  word_order;
    logic              jump_taken;

    assign word_order = word_in[WORD_W-1 -: ORD_W];
    assign jump_taken = (ctx_order_q == ORD_JUMP) || dev_jump_met;

    mcs_prio_arb #(.N(NSUB)) arb_i (
        .req (svc_req),
        .any (arb_any),
        .idx (arb_idx)
    );

    mcs_ctx_store #(.N(NSUB), .WORD_W(WORD_W)) ctx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (sel_q),
        .rd_phase (rd_phase),
        .rd_addr  (rd_addr),
        .rd_order (rd_order),
        .we       (st_q[S_UPD]),
        .wr_idx   (sel_q),
        .wr_phase (ctx_phase_q),
        .wr_addr  (ctx_addr_q),
        .wr_order (ctx_order_q)
    );

    mcs_order_dec dec_i (
        .cmd_step   (st_q[S_CMDF]),
        .reload     (reload_q),
        .cur_order  (ctx_order_q),
        .word_order (word_order),
        .nxt_phase  (dec_phase),
        .dcmd       (dec_cmd),
        .addr_load  (dec_addr_load)
    );

    // One-hot next-state selection
    always_comb begin
        st_d = '0;
        if (st_q[S_IDLE]) begin
            st_d[arb_any ? S_REQ : S_IDLE] = 1'b1;
        end else if (st_q[S_REQ]) begin
            st_d[poll_gnt ? S_POLL : S_REQ] = 1'b1;
        end else if (st_q[S_POLL]) begin
            unique case (ctx_phase_q)
                PH_CMD:  st_d[S_CMDF] = 1'b1;
                PH_ARGF: st_d[S_ARGF] = 1'b1;
                PH_ARGS: st_d[S_ARGS] = 1'b1;
                default: st_d[jump_taken ? S_ARGS : S_ARGF] = 1'b1;
            endcase
        end else if (st_q[S_CMDF]) begin
            st_d[xfer_done ? S_UPD : S_CMDF] = 1'b1;
        end else if (st_q[S_ARGF]) begin
            st_d[xfer_done ? S_UPD : S_ARGF] = 1'b1;
        end else if (st_q[S_ARGS]) begin
            st_d[xfer_done ? S_UPD : S_ARGS] = 1'b1;
        end else begin
            st_d[S_IDLE] = 1'b1;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= NST'(1) << S_IDLE;
        else        st_q <= st_d;
    end

    // Working context: select, poll load, step results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q       <= '0;
            ctx_phase_q <= PH_CMD;
            ctx_addr_q  <= '0;
            ctx_order_q <= '0;
            reload_q    <= 1'b0;
        end else begin
            if (st_q[S_IDLE] && arb_any) sel_q <= arb_idx;
            if (st_q[S_REQ] && poll_gnt) begin
                ctx_phase_q <= rd_phase;
                ctx_addr_q  <= rd_addr;
                ctx_order_q <= rd_order;
                reload_q    <= 1'b0;
            end
            if (st_q[S_POLL] && ctx_phase_q == PH_JMP && !jump_taken) reload_q <= 1'b1;
            if (st_q[S_CMDF] && xfer_done) begin
                ctx_order_q <= word_order;
                ctx_addr_q  <= ctx_addr_q + WORD_W'(1);
                ctx_phase_q <= dec_phase;
            end
            if (st_q[S_ARGF] && xfer_done) begin
                if (dec_addr_load) ctx_addr_q <= word_in;
                ctx_phase_q <= dec_phase;
            end
            if (st_q[S_ARGS] && xfer_done) ctx_phase_q <= PH_CMD;
        end
    end

    // Device command strobe, one cycle after a completed fetch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dcmd_vld_q  <= 1'b0;
            dcmd_q      <= DC_NONE;
            dcmd_word_q <= '0;
        end else begin
            dcmd_vld_q <= 1'b0;
            if ((st_q[S_CMDF] || st_q[S_ARGF]) && xfer_done) begin
                dcmd_vld_q  <= (dec_cmd != DC_NONE);
                dcmd_q      <= dec_cmd;
                dcmd_word_q <= word_in;
            end
        end
    end

    assign hs_req        = st_q[S_REQ];
    assign xfer_valid    = st_q[S_CMDF] | st_q[S_ARGF] | st_q[S_ARGS];
    assign xfer_to_mem   = st_q[S_ARGS];
    assign xfer_addr     = reload_q ? WORD_W'(sel_q) : ctx_addr_q;
    assign dev_cmd_valid = dcmd_vld_q;
    assign dev_cmd       = dcmd_q;
    assign dev_cmd_word  = dcmd_word_q;
    assign active_sub    = sel_q;

    logic [NSUB-1:0] below_mask;
    assign below_mask = (NSUB'(1) << arb_idx) - NSUB'(1);

    // R3: exactly one control state is active
    a_r3_state_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q) == 1);

    // R3: the request is held until the poll arrives
    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        hs_req && !poll_gnt |=> hs_req);

    // R3: the cycle after the poll carries neither request nor transfer
    a_r3_poll_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        hs_req && poll_gnt |=> !hs_req && !xfer_valid);

    // R4: a completed command fetch advances the program address by one
    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        st_q[S_CMDF] && xfer_done |=> ctx_addr_q == $past(ctx_addr_q) + WORD_W'(1));

    // R2: the arbiter picks a requesting index with no lower requester
    a_r2_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        arb_any |-> svc_req[arb_idx] && ((svc_req & below_mask) == '0));

    // R2: the serviced subchannel does not change during a transfer
    a_r2_sub_stable: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |=> $stable(active_sub));

    // R11: the device command strobe lasts one cycle
    a_r11_cmd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dev_cmd_valid |=> !dev_cmd_valid);

    // R11: a device command only follows a completed transfer
    a_r11_cmd_follows_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        dev_cmd_valid |-> $past(xfer_valid && xfer_done) && dev_cmd != 3'd0);
endmodule

// File: tb/mux_chan_seq_tb_top.sv
`timescale 1ns/1ps
// Bench: runs four service steps on each subchannel with an order code and
// jump condition taken from its index, then an overlapping-request sequence.
// Expected transfers and commands come from a small per-subchannel model.
module mux_chan_seq_tb_top;
    localparam int NSUB = 16;
    localparam int W    = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NSUB-1:0] svc_req = '0;
    logic          hs_req;
    logic          poll_gnt = 1'b0;
    logic          xfer_valid, xfer_to_mem;
    logic [W-1:0]  xfer_addr;
    logic          xfer_done = 1'b0;
    logic [W-1:0]  word_in = '0;
    logic          dev_cmd_valid;
    logic [2:0]    dev_cmd;
    logic [W-1:0]  dev_cmd_word;
    logic          dev_jump_met = 1'b0;
    logic [3:0]    active_sub;

    int n_checks = 0;
    int n_fail   = 0;
    int kcnt     = 0;

    // bench model: phase 0 cmd, 1 second fetch, 2 second store, 3 jump
    int           m_ph   [NSUB];
    logic [W-1:0] m_addr [NSUB];
    logic [3:0]   m_ord  [NSUB];

    always #4 clk = ~clk;

    mux_chan_seq #(.NSUB(NSUB), .WORD_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .svc_req(svc_req), .hs_req(hs_req),
        .poll_gnt(poll_gnt), .xfer_valid(xfer_valid), .xfer_to_mem(xfer_to_mem),
        .xfer_addr(xfer_addr), .xfer_done(xfer_done), .word_in(word_in),
        .dev_cmd_valid(dev_cmd_valid), .dev_cmd(dev_cmd), .dev_cmd_word(dev_cmd_word),
        .dev_jump_met(dev_jump_met), .active_sub(active_sub)
    );

    task automatic chk(input bit ok, input string tag, input int got, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    function automatic logic [3:0] ord_of(input int s);
        if (s <= 8) return 4'(s);
        if (s == 9) return 4'hF;
        return 4'(s - 10);
    endfunction

    task automatic service(input logic [15:0] mask, input logic [15:0] late, input logic met);
        int s, t, ph;
        logic [W-1:0] a, w, exp_a;
        logic [3:0] o;
        logic exp_to, exp_v;
        logic [2:0] exp_cmd;
        s = -1;
        for (int i = NSUB - 1; i >= 0; i--) if (mask[i]) s = i;
        @(negedge clk);
        svc_req = mask;
        dev_jump_met = met;
        t = 0;
        while (!hs_req && t < 50) begin
            @(negedge clk);
            t++;
        end
        chk(hs_req, "R3 request raised", int'(hs_req), 1);
        chk(active_sub == 4'(s), "R2 lowest index selected", int'(active_sub), s);
        svc_req = late;
        poll_gnt = 1'b1;
        @(negedge clk);
        poll_gnt = 1'b0;
        chk(!hs_req && !xfer_valid, "R3 quiet after poll", int'({hs_req, xfer_valid}), 0);
        ph = m_ph[s];
        a  = m_addr[s];
        o  = m_ord[s];
        kcnt++;
        w  = 16'(16'h0513 * kcnt + s);
        exp_v = 1'b0;
        exp_cmd = 3'd0;
        exp_a = a;
        exp_to = 1'b0;
        case (ph)
            0: begin
                w = {ord_of(s), w[11:0]};
                if (ord_of(s) == 4'd4) begin exp_v = 1'b1; exp_cmd = 3'd1; end
            end
            1: begin
                if (o == 4'd0) begin exp_v = 1'b1; exp_cmd = 3'd2; end
                if (o == 4'd1) begin exp_v = 1'b1; exp_cmd = 3'd3; end
                if (o == 4'd3) begin exp_v = 1'b1; exp_cmd = 3'd4; end
                if (o == 4'd4) begin exp_v = 1'b1; exp_cmd = 3'd1; end
            end
            2: exp_to = 1'b1;
            default: begin
                if (o == 4'd2 || met) exp_to = 1'b1;
                else exp_a = W'(s);
            end
        endcase
        @(negedge clk);
        chk(active_sub == 4'(s), "R2 selection held", int'(active_sub), s);
        case (ph)
            0: chk(xfer_valid && xfer_to_mem == exp_to && xfer_addr == exp_a,
                   "R1 R4 command fetch", int'({xfer_valid, xfer_to_mem, xfer_addr}),
                   int'({1'b1, exp_to, exp_a}));
            1: chk(xfer_valid && xfer_to_mem == exp_to && xfer_addr == exp_a,
                   "R5 R7 second-word fetch", int'({xfer_valid, xfer_to_mem, xfer_addr}),
                   int'({1'b1, exp_to, exp_a}));
            2: chk(xfer_valid && xfer_to_mem == exp_to && xfer_addr == exp_a,
                   "R5 R9 second-word store", int'({xfer_valid, xfer_to_mem, xfer_addr}),
                   int'({1'b1, exp_to, exp_a}));
            default: chk(xfer_valid && xfer_to_mem == exp_to && xfer_addr == exp_a,
                   "R10 jump step", int'({xfer_valid, xfer_to_mem, xfer_addr}),
                   int'({1'b1, exp_to, exp_a}));
        endcase
        xfer_done = 1'b1;
        word_in = w;
        @(negedge clk);
        xfer_done = 1'b0;
        chk(dev_cmd_valid == exp_v && (!exp_v || dev_cmd == exp_cmd),
            "R6 R8 R11 device command", int'({dev_cmd_valid, dev_cmd}), int'({exp_v, exp_cmd}));
        if (exp_v && exp_cmd == 3'd1)
            chk(dev_cmd_word == w, "R6 R7 control word", int'(dev_cmd_word), int'(w));
        // model update from the requirements
        case (ph)
            0: begin
                m_ord[s]  = w[15:12];
                m_addr[s] = a + 16'd1;
                m_ph[s]   = (w[15:12] <= 4'd5) ? 1 : 2;
            end
            1: begin
                if (o <= 4'd3 || o == 4'd5) m_addr[s] = w;
                m_ph[s] = (o == 4'd2 || o == 4'd3) ? 3 : 0;
            end
            2: m_ph[s] = 0;
            default: begin
                if (!exp_to) m_addr[s] = w;
                m_ph[s] = 0;
            end
        endcase
        @(negedge clk);
        chk(!dev_cmd_valid, "R11 strobe one cycle", int'(dev_cmd_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int s = 0; s < NSUB; s++) begin
            m_ph[s] = 0;
            m_addr[s] = W'(s) << 12;
            m_ord[s] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!hs_req && !xfer_valid && !dev_cmd_valid, "R1 reset outputs",
            int'({hs_req, xfer_valid, dev_cmd_valid}), 0);
        for (int s = 0; s < NSUB; s++) begin
            for (int k = 0; k < 4; k++) service(16'(1) << s, 16'h0000, (s < 8));
        end
        service(16'h1220, 16'h1200, 1'b0);
        service(16'h1200, 16'h1204, 1'b0);
        service(16'h1204, 16'h1000, 1'b0);
        service(16'h1000, 16'h0000, 1'b0);
        repeat (3) @(negedge clk);
        chk(!hs_req, "R2 no request when lines low", int'(hs_req), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule